// File: doc/BRIEF.md
# Systolic FIR Filter

This block is a one-dimensional systolic chain of identical multiply-accumulate cells that computes a finite impulse response over a stream of signed samples. Each cell owns one kernel coefficient. A partial sum starts at zero in the leftmost cell, and each cell adds its own product before passing the sum one register to the right. Samples enter only at the left end. They travel through a skew line that delays them by two registers per cell, so each coefficient meets the sample of the correct age. The finished sum leaves the rightmost cell together with a valid flag.

The coefficients are shifted in serially while the filter is idle. A shift also clears the sample history and the partial sums, so the new kernel starts from silence. The whole pipeline advances only on cycles that accept a sample. A gap in the input stream therefore freezes the pipeline without adding a zero sample to the history. With a continuous stream, the filter produces one result per clock once the chain is full, whatever the kernel length.

Top module: `sys_fir`

## Requirements
- R1: After reset, out_valid_o is low, out_data_o is zero, and every coefficient is zero.
- R2: Each cycle with coef_load_i high shifts coef_data_i into the kernel. Of the last TAPS words shifted in, the oldest becomes h[0], the tap that weights the newest sample, and the most recent becomes h[TAPS-1]. Words older than the last TAPS are discarded.
- R3: A load cycle clears the sample history and all partial sums, so out_data_o reads zero after the load. It ignores in_valid_i and in_data_i. out_valid_o then stays low until TAPS new samples have been accepted.
- R4: A sample is accepted on each clock edge where in_valid_i is 1 and coef_load_i is 0. The result for the j-th accepted sample is y(j) = sum over k of h[k]·x(j-k), where every sample before the first one accepted since reset or the last load counts as zero. An impulse therefore returns h[0] to h[TAPS-1] in order.
- R5: The result for sample j appears on out_data_o, with out_valid_o high, in the cycle after the edge that accepts sample j+TAPS-1. A continuous stream yields one valid result every cycle.
- R6: In a cycle after an edge that accepted no sample and performed no load, out_valid_o is low and out_data_o is unchanged.
- R7: Samples and coefficients are 16-bit two's complement values. Each product keeps all 32 bits and is sign-extended into a 40-bit two's complement sum, and the sum wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_load_i | input | 1 | Shift one coefficient word in; filter held idle |
| coef_data_i | input | 16 | Coefficient word, signed |
| in_valid_i | input | 1 | Sample present this cycle |
| in_data_i | input | 16 | Input sample, signed |
| out_valid_o | output | 1 | Result on out_data_o is valid this cycle |
| out_data_o | output | 40 | Filter result, signed |

## Verification
The assertions assume that coef_load_i and in_valid_i are known, 0 or 1, in every cycle after reset. They also assume that a load takes priority over a sample, so the hold properties apply only to cycles where neither input was active. The stimulus drives every input at a defined level from time zero. It raises in_valid_i during some load cycles so that the ignore rule is exercised without breaking that priority. The reference model follows the same acceptance rule: it takes a sample only when in_valid_i is 1 and coef_load_i is 0.

// File: rtl/sys_fir_pkg.sv
package sys_fir_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned COEF_W   = 16;
  localparam int unsigned ACC_W    = 40;
  localparam int unsigned PROD_W   = SAMPLE_W + COEF_W;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;
  typedef logic signed [PROD_W-1:0]   prod_t;
  typedef logic signed [ACC_W-1:0]    acc_t;
endpackage

// File: rtl/sys_fir_coef_bank.sv
module sys_fir_coef_bank
  import sys_fir_pkg::*;
#(
  parameter int unsigned TAPS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  coef_t                          data_i,
  output logic [TAPS-1:0][COEF_W-1:0]    coefs_o
);
  logic [TAPS-1:0][COEF_W-1:0] coef_q;

  // words enter at the far end and move toward cell 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q <= '0;
    end else if (load_i) begin
      coef_q[TAPS-1] <= data_i;
      for (int k = 0; k < int'(TAPS) - 1; k++) coef_q[k] <= coef_q[k+1];
    end
  end

  assign coefs_o = coef_q;

  // R2
  coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(coef_q));
endmodule

// File: rtl/sys_fir_sample_skew.sv
module sys_fir_sample_skew
  import sys_fir_pkg::*;
#(
  parameter int unsigned TAPS = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clear_i,
  input  logic                           en_i,
  input  sample_t                        x_i,
  output logic [TAPS-1:0][SAMPLE_W-1:0]  taps_o
);
  assign taps_o[0] = x_i;

  // two registers per hop so sample age grows by one per cell relative to the sum
  for (genvar k = 0; k < int'(TAPS) - 1; k++) begin : g_hop
    sample_t a_q, b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        b_q <= '0;
      end else if (clear_i) begin
        a_q <= '0;
        b_q <= '0;
      end else if (en_i) begin
        a_q <= taps_o[k];
        b_q <= a_q;
      end
    end
    assign taps_o[k+1] = b_q;

    // R3
    hop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (a_q == '0) && (b_q == '0));
  end
endmodule

// File: rtl/sys_fir_mac_cell.sv
module sys_fir_mac_cell
  import sys_fir_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clear_i,
  input  logic    en_i,
  input  coef_t   coef_i,
  input  sample_t x_i,
  input  acc_t    ps_i,
  output acc_t    ps_o
);
  prod_t prod;
  acc_t  prod_ext;
  acc_t  ps_q;

  assign prod     = coef_i * x_i;
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ps_q <= '0;
    else if (clear_i) ps_q <= '0;
    else if (en_i)    ps_q <= ps_i + prod_ext;
  end

  assign ps_o = ps_q;

  // R6
  psum_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(ps_o));
endmodule

// File: rtl/sys_fir_fill_track.sv
module sys_fir_fill_track #(
  parameter int unsigned TAPS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic adv_i,
  output logic valid_o
);
  localparam int unsigned CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TAPS);

  logic [CNT_W-1:0] cnt_q;
  logic             adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adv_q <= 1'b0;
    end else begin
      adv_q <= adv_i && !clear_i;
      if (clear_i)                    cnt_q <= '0;
      else if (adv_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = adv_q && (cnt_q == FULL);

  // R3
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_o);
endmodule

// File: rtl/sys_fir.sv
module sys_fir
  import sys_fir_pkg::*;
#(
  parameter int unsigned TAPS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       coef_load_i,
  input  logic signed [COEF_W-1:0]   coef_data_i,
  input  logic                       in_valid_i,
  input  logic signed [SAMPLE_W-1:0] in_data_i,
  output logic                       out_valid_o,
  output logic signed [ACC_W-1:0]    out_data_o
);
  logic                          adv;
  logic [TAPS-1:0][COEF_W-1:0]   coefs;
  logic [TAPS-1:0][SAMPLE_W-1:0] x_tap;
  acc_t                          ps_link [TAPS+1];

  // load wins over a sample in the same cycle
  assign adv = in_valid_i && !coef_load_i;

  sys_fir_coef_bank #(.TAPS(TAPS)) coef_bank_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (coef_load_i),
    .data_i  (coef_data_i),
    .coefs_o (coefs)
  );

  sys_fir_sample_skew #(.TAPS(TAPS)) skew_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (coef_load_i),
    .en_i    (adv),
    .x_i     (in_data_i),
    .taps_o  (x_tap)
  );

  assign ps_link[0] = '0;

  for (genvar k = 0; k < int'(TAPS); k++) begin : g_cell
    sys_fir_mac_cell cell_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (coef_load_i),
      .en_i    (adv),
      .coef_i  (coefs[k]),
      .x_i     (x_tap[k]),
      .ps_i    (ps_link[k]),
      .ps_o    (ps_link[k+1])
    );
  end

  sys_fir_fill_track #(.TAPS(TAPS)) fill_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (coef_load_i),
    .adv_i   (adv),
    .valid_o (out_valid_o)
  );

  assign out_data_o = ps_link[TAPS];

  // R5
  out_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i && !coef_load_i));

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(in_valid_i) && !$past(coef_load_i)) |-> ($stable(out_data_o) && !out_valid_o));

  // R3
  out_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_load_i |=> (out_data_o == '0));
endmodule

// File: tb/sys_fir_tb_top.sv
module sys_fir_tb_top;
  import sys_fir_pkg::*;

  localparam int unsigned TAPS = 8;

  logic    clk_i = 1'b0;
  logic    rst_ni = 1'b0;
  logic    coef_load_i = 1'b0;
  coef_t   coef_data_i = '0;
  logic    in_valid_i = 1'b0;
  sample_t in_data_i = '0;
  logic    out_valid_o;
  acc_t    out_data_o;

  sys_fir #(.TAPS(TAPS)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .coef_load_i (coef_load_i),
    .coef_data_i (coef_data_i),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  always #2 clk_i = ~clk_i;

  int      n_cmp = 0;
  int      n_bad = 0;
  int      n_cyc = 0;
  bit      done = 1'b0;
  string   tag = "R1";

  // reference model state
  longint  hc [TAPS];
  longint  hist [$];
  int      n_acc = 0;
  logic    exp_valid = 1'b0;
  acc_t    exp_data = '0;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    n_cyc++;
    if (n_cyc > 100000 && !done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", n_cyc);
      finish_run();
    end
  end

  task automatic model(input logic ld, input coef_t cd, input logic v, input sample_t d);
    longint s;
    if (ld) begin
      for (int k = 0; k < int'(TAPS) - 1; k++) hc[k] = hc[k+1];
      hc[TAPS-1] = longint'(cd);
      hist.delete();
      n_acc     = 0;
      exp_valid = 1'b0;
      exp_data  = '0;
    end else if (v) begin
      hist.push_front(longint'(d));
      if (hist.size() > 2 * TAPS) void'(hist.pop_back());
      n_acc++;
      s = 0;
      for (int k = 0; k < int'(TAPS); k++)
        if (TAPS - 1 + k < hist.size()) s += hc[k] * hist[TAPS-1+k];
      exp_data  = ACC_W'(s);
      exp_valid = (n_acc >= TAPS);
    end else begin
      exp_valid = 1'b0;
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (out_valid_o !== exp_valid || out_data_o !== exp_data) begin
      n_bad++;
      $display("FAIL %s: actual valid=%0b data=%0d expected valid=%0b data=%0d",
               tag, out_valid_o, out_data_o, exp_valid, exp_data);
    end
  endtask

  task automatic cyc(input logic ld, input coef_t cd, input logic v, input sample_t d);
    coef_load_i = ld;
    coef_data_i = cd;
    in_valid_i  = v;
    in_data_i   = d;
    @(posedge clk_i);
    model(ld, cd, v, d);
    #1;
    compare();
  endtask

  task automatic load_kernel(input int base, input int stride);
    for (int k = 0; k < int'(TAPS); k++) cyc(1'b1, coef_t'(base + k * stride), 1'b0, '0);
  endtask

  initial begin
    for (int k = 0; k < int'(TAPS); k++) hc[k] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tag = "R1 reset state";
    compare();
    cyc(1'b0, '0, 1'b1, 16'sd100);  // R1: zero kernel gives zero output

    // R2 serial load order, R4 impulse returns kernel in order
    tag = "R2 load";
    load_kernel(3, -5);
    tag = "R4 impulse";
    cyc(1'b0, '0, 1'b1, 16'sd1);
    for (int i = 0; i < 3 * int'(TAPS); i++) cyc(1'b0, '0, 1'b1, '0);

    // R5 continuous stream: step response, one result per cycle
    tag = "R5 step";
    for (int i = 0; i < 3 * int'(TAPS); i++) cyc(1'b0, '0, 1'b1, 16'sd7);

    // R6 gapped random stream
    tag = "R6 gaps";
    for (int i = 0; i < 400; i++)
      cyc(1'b0, '0, ($urandom_range(0, 2) != 0), sample_t'($urandom));

    // R3 load with in_valid high: samples ignored, history cleared
    tag = "R3 load ignores samples";
    for (int k = 0; k < int'(TAPS); k++) cyc(1'b1, coef_t'($urandom), 1'b1, 16'sd9999);
    tag = "R3 refill";
    for (int i = 0; i < 2 * int'(TAPS); i++) cyc(1'b0, '0, 1'b1, sample_t'($urandom));

    // R2 over-long load discards the oldest words
    tag = "R2 overload";
    for (int k = 0; k < int'(TAPS) + 3; k++) cyc(1'b1, coef_t'(k * 11 - 40), 1'b0, '0);
    tag = "R4 random";
    for (int i = 0; i < 300; i++)
      cyc(1'b0, '0, ($urandom_range(0, 4) != 0), sample_t'($urandom));

    // R7 extreme operands
    tag = "R7 extremes";
    for (int k = 0; k < int'(TAPS); k++) cyc(1'b1, -16'sd32768, 1'b0, '0);
    for (int i = 0; i < 2 * int'(TAPS); i++) cyc(1'b0, '0, 1'b1, -16'sd32768);
    for (int i = 0; i < 2 * int'(TAPS); i++)
      cyc(1'b0, '0, 1'b1, (i % 2 == 0) ? 16'sd32767 : -16'sd32768);

    // R6 idle tail keeps output frozen
    tag = "R6 idle";
    for (int i = 0; i < 10; i++) cyc(1'b0, '0, 1'b0, 16'sd123);

    finish_run();
  end
endmodule